// File: doc/BRIEF.md
# Burst Memory Slave with Byte Lanes

This block is an on-chip memory that sits on a memory-mapped bus as a slave. It serves single and burst reads and writes. The bus address counts bytes, and one data word holds `DATA_WIDTH/8` bytes. Write beats apply per-byte enables. Read words come back on a registered data path with a valid strobe. Each completed write burst produces a one-cycle write response.

A build-time switch decides how byte addresses that are not word-aligned are handled. When the switch is on, every beat covers the bytes starting at its own byte address, so a beat's bytes can span two adjacent words. When the switch is off, such a command is dropped and an error pulse is raised.

The memory keeps a written flag per byte. Each read word reports whether any of its bytes was never written. A request with both read and write asserted first returns the old contents of the burst, then accepts the write beats for the same address.

Top module: `amm_burst_mem`

## Requirements
- R1: A read command with burstcount N (N >= 1) returns N words. Byte j of word i equals the memory byte at (address + i*BYTES + j) modulo the memory size. This holds for aligned addresses, and also for unaligned ones when ALLOW_UNALIGNED is 1.
- R2: Write beat i of a burst (i counted from 0) stores writedata bits [8j+7:8j] at byte (address + i*BYTES + j) only where byteenable[j] is 1. A beat with byteenable 0 leaves memory unchanged.
- R3: The first word of a read appears with readdatavalid high in the cycle after the command is accepted. The remaining words follow on consecutive cycles, and readdatavalid falls after the last word.
- R4: While a read burst still has words to return after the one currently presented, waitrequest is 1. It is 0 while the last word is presented.
- R5: writeresponsevalid is 1 for exactly one cycle, the cycle after the last beat of a write burst is accepted, and it is 0 after earlier beats. The response output is 2'b00 (okay) with every read word and every write response.
- R6: A request with read and write both at 1 is held off with waitrequest in its first cycle. It then returns the pre-write contents of the N words as in R1 and R3. After that, its N write beats are accepted and stored at the same address as in R2.
- R7: rd_uninit is 1 together with a read word exactly when at least one byte of that word has not been written since reset. It is 0 whenever readdatavalid is 0.
- R8: With ALLOW_UNALIGNED at 0, any accepted command or beat whose address modulo BYTES is not 0 raises addr_err for one cycle, one cycle later. Such a beat stores nothing, and such a command returns no read data and no write response.
- R9: Byte addresses wrap modulo DEPTH*BYTES, including inside a word that straddles the top of memory.
- R10: After reset, waitrequest, readdatavalid, writeresponsevalid and addr_err are 0, and every byte reads as not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| address | input | ADDR_W | Byte address of the command |
| burstcount | input | BCW | Number of words in the burst (>= 1) |
| read | input | 1 | Read request |
| write | input | 1 | Write beat request |
| writedata | input | DATA_WIDTH | Write beat data |
| byteenable | input | DATA_WIDTH/8 | Per-byte write enable |
| waitrequest | output | 1 | Slave not ready to accept the current request |
| readdata | output | DATA_WIDTH | Returned read word |
| readdatavalid | output | 1 | readdata is valid this cycle |
| response | output | 2 | Response code, always okay (00) |
| writeresponsevalid | output | 1 | Write burst completion pulse |
| rd_uninit | output | 1 | Returned word contains bytes never written |
| addr_err | output | 1 | Misaligned command dropped (strict build only) |

## Verification
The assertions assume the following about the host:
- burstcount is at least 1.
- address, burstcount and the read/write pair stay stable across all beats of a burst and while waitrequest is 1.
- No new command starts before the previous burst's beats are complete.

The bench issues each operation from one task that holds the command until the beat is accepted, and it only starts a new operation after the previous one has drained. The small configuration (four-byte words, 64 bytes) is swept over every byte address and every byte-enable pattern at every offset. Bursts up to eight words, wrap-around and combined requests are also covered. A second instance built without unaligned support covers the dropped commands.

// File: rtl/amm_bmem_pkg.sv
package amm_bmem_pkg;

  // Byte address of beat "beat" of a burst starting at byte address "base".
  function automatic logic [31:0] beat_base(input logic [31:0] base,
                                            input logic [31:0] beat,
                                            input int unsigned bytes);
    return base + beat * bytes;
  endfunction

  // True when the byte address does not fall on a word boundary.
  function automatic logic off_word(input logic [31:0] addr,
                                    input int unsigned bytes);
    return (addr % bytes) != 0;
  endfunction

endpackage

// File: rtl/bmem_store.sv
module bmem_store #(
  parameter int BYTES = 4,
  parameter int DEPTH = 16,
  localparam int SPAN = BYTES * DEPTH,
  localparam int AW   = $clog2(SPAN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        wa,
  input  logic [8*BYTES-1:0]   wdata,
  input  logic [BYTES-1:0]     wbe,
  input  logic [AW-1:0]        ra,
  output logic [8*BYTES-1:0]   rword,
  output logic                 runinit
);
  logic [7:0]      bytes_q [SPAN];
  logic [SPAN-1:0] init_q;
  logic [AW-1:0]   wl [BYTES];
  logic [AW-1:0]   rl [BYTES];
  logic [BYTES-1:0] miss;

  // Each lane addresses its own byte; the AW-bit sum wraps at the top.
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign wl[g] = wa + AW'(g);
    assign rl[g] = ra + AW'(g);
    assign rword[8*g +: 8] = bytes_q[rl[g]];
    assign miss[g] = !init_q[rl[g]];
  end
  assign runinit = |miss;

  always_ff @(posedge clk) begin
    for (int j = 0; j < BYTES; j++)
      if (we && wbe[j]) bytes_q[wl[j]] <= wdata[8*j +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) init_q <= '0;
    else
      for (int j = 0; j < BYTES; j++)
        if (we && wbe[j]) init_q[wl[j]] <= 1'b1;
  end
endmodule

// File: rtl/bmem_rd_seq.sv
module bmem_rd_seq #(
  parameter int BYTES = 4,
  parameter int AW    = 6,
  parameter int BCW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [AW-1:0]      base,
  input  logic [BCW-1:0]     count,
  input  logic [8*BYTES-1:0] mem_word,
  input  logic               mem_uninit,
  output logic [AW-1:0]      fetch_addr,
  output logic [8*BYTES-1:0] rdata,
  output logic               rvalid,
  output logic               runinit,
  output logic               busy
);
  logic [BCW-1:0] left_q;
  logic [AW-1:0]  next_q;
  logic           fetch;

  assign busy       = left_q != '0;
  assign fetch      = launch || busy;
  assign fetch_addr = launch ? base : next_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      next_q  <= '0;
      rvalid  <= 1'b0;
      runinit <= 1'b0;
    end else begin
      if (launch) begin
        left_q <= count - BCW'(1);
        next_q <= base + AW'(BYTES);
      end else if (busy) begin
        left_q <= left_q - BCW'(1);
        next_q <= next_q + AW'(BYTES);
      end
      rvalid  <= fetch;
      runinit <= fetch && mem_uninit;
    end
  end

  always_ff @(posedge clk) begin
    if (fetch) rdata <= mem_word;
  end
endmodule

// File: rtl/bmem_wr_seq.sv
module bmem_wr_seq #(
  parameter int BCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           beat,
  input  logic           store_ok,
  input  logic [BCW-1:0] count,
  output logic [BCW-1:0] idx,
  output logic           last,
  output logic           wresp
);
  assign last = idx == count - BCW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      wresp <= 1'b0;
    end else begin
      if (beat) idx <= last ? '0 : idx + BCW'(1);
      wresp <= beat && last && store_ok;
    end
  end
endmodule

// File: rtl/amm_burst_mem.sv
module amm_burst_mem
  import amm_bmem_pkg::*;
#(
  parameter int DATA_WIDTH      = 32,
  parameter int DEPTH           = 16,
  parameter int ADDR_W          = 8,
  parameter int BCW             = 4,
  parameter bit ALLOW_UNALIGNED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       address,
  input  logic [BCW-1:0]          burstcount,
  input  logic                    read,
  input  logic                    write,
  input  logic [DATA_WIDTH-1:0]   writedata,
  input  logic [DATA_WIDTH/8-1:0] byteenable,
  output logic                    waitrequest,
  output logic [DATA_WIDTH-1:0]   readdata,
  output logic                    readdatavalid,
  output logic [1:0]              response,
  output logic                    writeresponsevalid,
  output logic                    rd_uninit,
  output logic                    addr_err
);
  localparam int BYTES = DATA_WIDTH / 8;
  localparam int SPAN  = BYTES * DEPTH;
  localparam int AW    = $clog2(SPAN);
  localparam int OFFW  = $clog2(BYTES);

  // Named internal events
  logic            misal, rd_busy, rmw_q, rmw_start, rd_accept, rd_launch;
  logic            wr_beat, wr_store, wr_last;
  logic [BCW-1:0]  wr_idx;
  logic [AW-1:0]   addr_lo, wr_addr, fetch_addr;
  logic [DATA_WIDTH-1:0] mem_word;
  logic            mem_uninit;

  assign addr_lo   = address[AW-1:0];
  assign misal     = !ALLOW_UNALIGNED && off_word(32'(address), BYTES);
  assign rmw_start = read && write && !rmw_q && !rd_busy;
  assign rd_accept = read && !write && !rd_busy;
  assign rd_launch = (rd_accept || rmw_start) && !misal;
  assign waitrequest = rd_busy || (read && write && !rmw_q);
  assign wr_beat   = write && !waitrequest && (!read || rmw_q);
  assign wr_store  = wr_beat && !misal;
  assign wr_addr   = AW'(beat_base(32'(addr_lo), 32'(wr_idx), BYTES));
  assign response  = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmw_q    <= 1'b0;
      addr_err <= 1'b0;
    end else begin
      if (rmw_start)               rmw_q <= 1'b1;
      else if (wr_beat && wr_last) rmw_q <= 1'b0;
      addr_err <= misal && (rd_accept || rmw_start || wr_beat);
    end
  end

  bmem_store #(.BYTES(BYTES), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_store), .wa(wr_addr),
    .wdata(writedata), .wbe(byteenable), .ra(fetch_addr),
    .rword(mem_word), .runinit(mem_uninit));

  bmem_rd_seq #(.BYTES(BYTES), .AW(AW), .BCW(BCW)) u_rd (
    .clk(clk), .rst_n(rst_n), .launch(rd_launch), .base(addr_lo),
    .count(burstcount), .mem_word(mem_word), .mem_uninit(mem_uninit),
    .fetch_addr(fetch_addr), .rdata(readdata), .rvalid(readdatavalid),
    .runinit(rd_uninit), .busy(rd_busy));

  bmem_wr_seq #(.BCW(BCW)) u_wr (
    .clk(clk), .rst_n(rst_n), .beat(wr_beat), .store_ok(!misal),
    .count(burstcount), .idx(wr_idx), .last(wr_last),
    .wresp(writeresponsevalid));
endmodule

// File: rtl/amm_burst_mem_chk.sv
module amm_burst_mem_chk #(
  parameter int OFFW            = 2,
  parameter bit ALLOW_UNALIGNED = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            read,
  input logic            write,
  input logic [OFFW-1:0] addr_low,
  input logic            waitrequest,
  input logic            readdatavalid,
  input logic            rd_uninit,
  input logic            writeresponsevalid,
  input logic            addr_err
);
  AST_WAIT_IMPLIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (waitrequest && !(read && write)) |=> readdatavalid); // R4
  AST_FIRST_DATA_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(readdatavalid) |-> $past(read)); // R3
  AST_UNINIT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_uninit |-> readdatavalid); // R7
  AST_WRESP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    writeresponsevalid |-> $past(write && !waitrequest)); // R5
  AST_ERR_ONLY_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!ALLOW_UNALIGNED && $past(addr_low != '0))); // R8
endmodule

bind amm_burst_mem amm_burst_mem_chk #(.OFFW(OFFW), .ALLOW_UNALIGNED(ALLOW_UNALIGNED)) u_chk (
  .clk(clk), .rst_n(rst_n), .read(read), .write(write),
  .addr_low(address[OFFW-1:0]), .waitrequest(waitrequest),
  .readdatavalid(readdatavalid), .rd_uninit(rd_uninit),
  .writeresponsevalid(writeresponsevalid), .addr_err(addr_err));

// File: tb/amm_burst_mem_tb.sv
module amm_burst_mem_tb;
  localparam int SZ = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  address = '0;
  logic [3:0]  burstcount = 4'd1, byteenable = '0;
  logic        read = 1'b0, write = 1'b0;
  logic [31:0] writedata = '0, readdata;
  logic        waitrequest, readdatavalid, writeresponsevalid, rd_uninit, addr_err;
  logic [1:0]  response;

  logic [7:0]  s_address = '0;
  logic        s_read = 1'b0, s_write = 1'b0;
  logic [31:0] s_wdata = '0, s_rdata;
  logic        s_wait, s_rdv, s_wresp, s_uninit, s_err;
  logic [1:0]  s_resp;

  amm_burst_mem #(.DATA_WIDTH(32), .DEPTH(16), .ADDR_W(8), .BCW(4), .ALLOW_UNALIGNED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .address(address), .burstcount(burstcount),
    .read(read), .write(write), .writedata(writedata), .byteenable(byteenable),
    .waitrequest(waitrequest), .readdata(readdata), .readdatavalid(readdatavalid),
    .response(response), .writeresponsevalid(writeresponsevalid),
    .rd_uninit(rd_uninit), .addr_err(addr_err));

  amm_burst_mem #(.DATA_WIDTH(32), .DEPTH(16), .ADDR_W(8), .BCW(4), .ALLOW_UNALIGNED(1'b0)) u_dut_strict (
    .clk(clk), .rst_n(rst_n), .address(s_address), .burstcount(4'd1),
    .read(s_read), .write(s_write), .writedata(s_wdata), .byteenable(4'hF),
    .waitrequest(s_wait), .readdata(s_rdata), .readdatavalid(s_rdv),
    .response(s_resp), .writeresponsevalid(s_wresp),
    .rd_uninit(s_uninit), .addr_err(s_err));

  int checks = 0, errors = 0, seed = 0;
  logic [7:0] mref [SZ];
  bit         minit [SZ];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_word();
    seed++;
    return 32'h3C6EF372 ^ (32'(seed) * 32'h01000193);
  endfunction

  // Expect n read words at consecutive negedges, starting now (negedge+0).
  task automatic check_words(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] exp, msk;
      bit unin;
      if (i > 0) @(negedge clk);
      #1;
      exp = '0; msk = '0; unin = 0;
      for (int j = 0; j < 4; j++) begin
        int k;
        k = (a + i*4 + j) % SZ;
        exp[8*j +: 8] = mref[k];
        if (minit[k]) msk[8*j +: 8] = 8'hFF; else unin = 1;
      end
      chk(readdatavalid === 1'b1, "R3", "readdatavalid", 64'(readdatavalid), 64'd1);
      chk((((readdata ^ exp) & msk) === 32'd0) && response === 2'b00, "R1", "read word",
          64'(readdata & msk), 64'(exp & msk));
      chk(rd_uninit === unin, "R7", "rd_uninit", 64'(rd_uninit), 64'(unin));
      if (n > 1) chk(waitrequest === (i < n-1), "R4", "waitrequest during drain",
                     64'(waitrequest), 64'(i < n-1));
    end
  endtask

  // Write beats; starts just after a negedge with command held.
  task automatic beats(input int a, input int n, input logic [3:0] be);
    for (int i = 0; i < n; i++) begin
      logic [31:0] wd;
      wd = next_word();
      writedata = wd; byteenable = be;
      #1;
      while (waitrequest) begin @(negedge clk); #1; end
      @(posedge clk);
      for (int j = 0; j < 4; j++)
        if (be[j]) begin
          int k;
          k = (a + i*4 + j) % SZ;
          mref[k] = wd[8*j +: 8];
          minit[k] = 1;
        end
      @(negedge clk); #1;
      chk(writeresponsevalid === (i == n-1) && response === 2'b00, "R5", "write response",
          64'(writeresponsevalid), 64'(i == n-1));
    end
  endtask

  task automatic op_write(input int a, input int n, input logic [3:0] be);
    address = 8'(a); burstcount = 4'(n); write = 1'b1; read = 1'b0;
    beats(a, n, be);
    write = 1'b0;
    @(negedge clk); #1;
    chk(writeresponsevalid === 1'b0, "R5", "single response", 64'(writeresponsevalid), 64'd0);
  endtask

  task automatic op_read(input int a, input int n);
    address = 8'(a); burstcount = 4'(n); read = 1'b1; write = 1'b0;
    #1;
    while (waitrequest) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    read = 1'b0;
    check_words(a, n);
    @(negedge clk); #1;
    chk(readdatavalid === 1'b0, "R3", "valid ends after burst", 64'(readdatavalid), 64'd0);
  endtask

  task automatic op_rmw(input int a, input int n);
    address = 8'(a); burstcount = 4'(n); read = 1'b1; write = 1'b1;
    #1;
    chk(waitrequest === 1'b1, "R6", "combined request held first cycle", 64'(waitrequest), 64'd1);
    @(posedge clk);
    @(negedge clk);
    check_words(a, n);
    beats(a, n, 4'hF);
    read = 1'b0; write = 1'b0;
    @(negedge clk); #1;
    chk(readdatavalid === 1'b0 && writeresponsevalid === 1'b0, "R6", "combined request idle",
        64'({readdatavalid, writeresponsevalid}), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < SZ; k++) begin mref[k] = '0; minit[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk({waitrequest, readdatavalid, writeresponsevalid, addr_err} === 4'b0, "R10", "outputs after reset",
        64'({waitrequest, readdatavalid, writeresponsevalid, addr_err}), 64'd0);
    op_read(0, 1);  // R10: all bytes not written -> uninit
    op_write(8, 1, 4'b0001);  // R7 partial word
    op_read(8, 1);
    op_write(20, 1, 4'b0000); // R2 zero enables change nothing
    op_read(20, 1);
    // Fill memory with 8-word bursts, then read every byte address (R1, R9)
    op_write(0, 8, 4'hF);
    op_write(32, 8, 4'hF);
    for (int a = 0; a < SZ; a++) op_read(a, 1);
    op_read(60, 2); // R9 wrap across the top
    // R2: every enable pattern at every offset
    for (int off = 0; off < 4; off++)
      for (int be = 0; be < 16; be++) begin
        op_write(32 + off, 1, 4'(be));
        op_read(32, 2);
      end
    // Bursts of 1..8 at unaligned bases
    for (int n = 1; n <= 8; n++) begin
      op_write(5 + n, n, 4'hF);
      op_read(5 + n, n);
    end
    op_write(58, 3, 4'hF); // R9 burst wrapping the top
    op_read(58, 3);
    // R6 combined read-then-write
    op_rmw(10, 3);
    op_read(10, 3);
    op_rmw(62, 2);
    op_read(62, 2);

    // R8 strict build
    s_address = 8'd0; s_wdata = 32'hA5A50001; s_write = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    chk(s_wresp === 1'b1 && s_err === 1'b0, "R8", "aligned write in strict build",
        64'({s_wresp, s_err}), 64'b10);
    s_address = 8'd1; s_wdata = 32'h5A5A5A5A;
    @(posedge clk); @(negedge clk); #1;
    chk(s_err === 1'b1 && s_wresp === 1'b0, "R8", "misaligned write dropped",
        64'({s_wresp, s_err}), 64'b01);
    s_write = 1'b0; s_read = 1'b1; s_address = 8'd0;
    @(posedge clk); @(negedge clk); #1;
    s_read = 1'b0;
    chk(s_rdv === 1'b1 && s_rdata === 32'hA5A50001 && s_err === 1'b0, "R8", "memory unchanged",
        64'(s_rdata), 64'hA5A50001);
    s_read = 1'b1; s_address = 8'd2;
    @(posedge clk); @(negedge clk); #1;
    s_read = 1'b0;
    chk(s_err === 1'b1 && s_rdv === 1'b0, "R8", "misaligned read dropped",
        64'({s_rdv, s_err}), 64'b01);
    @(negedge clk); #1;
    chk(s_err === 1'b0, "R8", "error is one pulse", 64'(s_err), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule